// File: doc/BRIEF.md
# Early Eviction Trigger for Oversubscribed Device Memory

This block decides when device memory should start handing pages back to the host before it is completely full. The aim is for the device-to-host copy of a victim range to run alongside the host-to-device copy that serves a page fault, instead of after it. The fault handler marks a fault, then marks the moment the new device page has been allocated. At that moment the block looks at four inputs: the size of the allocation, the free memory left, whether memory is oversubscribed, and whether the running workload is of the regular class. If every condition holds, the block raises a one-cycle eviction request with a byte count for the device-to-host DMA channel.

The byte count comes from the allocation size. It is cut down to whole pages, raised to one page if smaller, and capped at a per-request maximum. Only one eviction may be outstanding at a time. The DMA channel closes it with a completion pulse. A running count of issued requests is reported.

Top module: `evict_trigger`

## Requirements
- R1: While reset is asserted and right after it, `evict_req` is 0, `evict_count` is 0, no fault is pending and no eviction is outstanding.
- R2: The trigger condition is evaluated only in a cycle where `alloc_done` is 1 and a fault is pending. A fault is pending if `fault_evt` was seen since the last `alloc_done`, or if `fault_evt` is 1 in that same cycle. An `alloc_done` with no pending fault, or a fault with no `alloc_done`, never produces a request.
- R3: A request needs all three of these: `alloc_bytes > free_bytes`, `oversub` = 1, and `free_bytes` strictly below THRESH_BYTES (default 2097152). With `free_bytes` equal to the threshold, no request is made.
- R4: `evict_req` rises in the cycle after the qualifying `alloc_done` and lasts exactly one cycle. `evict_bytes` holds the request size while `evict_req` is 1.
- R5: The request size is `alloc_bytes` rounded down to a multiple of PAGE_BYTES (default 65536). It is raised to one page if that gives zero, and capped at MAX_EVICT_BYTES (default 2097152).
- R6: When `regular_en` is 0 (irregular workload), no request is issued. A pending fault is still consumed by `alloc_done`.
- R7: After a request, no new request issues until `evict_done` is seen. An `evict_done` in the same cycle as a qualifying `alloc_done` allows that request. A qualifying event that arrives while an eviction is outstanding is dropped, not queued.
- R8: `evict_count` goes up by one, wrapping, in the same cycle that `evict_req` is 1. Otherwise it holds its value.
- R9: A pending fault stays pending through idle cycles and is used up by exactly one `alloc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_evt | input | 1 | A page fault has been raised |
| alloc_done | input | 1 | The faulting page's device allocation succeeded |
| alloc_bytes | input | 32 | Requested allocation size in bytes |
| free_bytes | input | 32 | Device memory currently free, in bytes |
| oversub | input | 1 | Device memory is oversubscribed |
| regular_en | input | 1 | 1 = regular workload class, trigger enabled |
| evict_done | input | 1 | The device-to-host channel finished the outstanding eviction |
| evict_req | output | 1 | One-cycle eviction request |
| evict_bytes | output | 32 | Bytes to evict, valid with `evict_req` |
| evict_count | output | 16 | Number of requests issued, wrapping |

## Verification
Two events can land in the same cycle here. The completion of the outstanding eviction can arrive in the very cycle a new allocation qualifies. A fault and its allocation-complete can also arrive together. The bench drives `evict_done` and a qualifying `alloc_done` on the same clock, and it also drives `fault_evt` together with `alloc_done`. In both cases it expects a request on the next cycle. It also checks that, without the completion, the same qualifying allocation is dropped, and it compares every cycle against a behavioural model of pending, busy and count.

// File: rtl/evict_trigger_pkg.sv
package evict_trigger_pkg;
   typedef enum logic {
      EV_IDLE = 1'b0,
      EV_BUSY = 1'b1
   } ev_state_e;
endpackage

// File: rtl/evt_fault_latch.sv
module evt_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_evt,
   input  logic alloc_done,
   output logic fault_seen
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend_q <= 1'b0;
      else if (alloc_done) pend_q <= 1'b0;
      else if (fault_evt)  pend_q <= 1'b1;
   end

   assign fault_seen = pend_q | fault_evt;
endmodule

// File: rtl/evt_qualify.sv
module evt_qualify #(
   parameter int BYTE_W       = 32,
   parameter int THRESH_BYTES = 2097152
) (
   input  logic              fault_seen,
   input  logic              alloc_done,
   input  logic [BYTE_W-1:0] alloc_bytes,
   input  logic [BYTE_W-1:0] free_bytes,
   input  logic              oversub,
   input  logic              regular_en,
   output logic              cond
);
   localparam logic [BYTE_W-1:0] THRESH_V = BYTE_W'(THRESH_BYTES);

   logic short_of_space;
   logic low_water;

   always_comb begin
      short_of_space = alloc_bytes > free_bytes;
      low_water      = free_bytes < THRESH_V;
      cond = alloc_done & fault_seen & regular_en & oversub & short_of_space & low_water;
   end
endmodule

// File: rtl/evt_sizer.sv
module evt_sizer #(
   parameter int BYTE_W     = 32,
   parameter int PAGE_SHIFT = 16,
   parameter int MAX_PAGES  = 32
) (
   input  logic [BYTE_W-PAGE_SHIFT-1:0] pages_i,
   output logic [BYTE_W-1:0]            size_o
);
   localparam int PG_W = BYTE_W - PAGE_SHIFT;
   localparam logic [PG_W-1:0] MAX_V = PG_W'(MAX_PAGES);
   localparam logic [PG_W-1:0] ONE_V = PG_W'(1);

   logic [PG_W-1:0] sel;

   always_comb begin
      if (pages_i == '0)       sel = ONE_V;
      else if (pages_i > MAX_V) sel = MAX_V;
      else                      sel = pages_i;
      size_o = {sel, {PAGE_SHIFT{1'b0}}};
   end
endmodule

// File: rtl/evt_issuer.sv
module evt_issuer
   import evict_trigger_pkg::*;
#(
   parameter int BYTE_W  = 32,
   parameter int CNT_W   = 16,
   parameter bit CNT_SAT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cond,
   input  logic [BYTE_W-1:0] size_i,
   input  logic              evict_done,
   output logic              evict_req,
   output logic [BYTE_W-1:0] evict_bytes,
   output logic [CNT_W-1:0]  evict_count
);
   ev_state_e        state_q;
   logic             fire;
   logic [CNT_W-1:0] cnt_next;

   assign fire = cond & ((state_q == EV_IDLE) | evict_done);

   generate
      if (CNT_SAT) begin : g_sat
         assign cnt_next = (&evict_count) ? evict_count : evict_count + 1'b1;
      end else begin : g_wrap
         assign cnt_next = evict_count + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= EV_IDLE;
         evict_req   <= 1'b0;
         evict_bytes <= '0;
         evict_count <= '0;
      end else begin
         evict_req <= fire;
         if (fire) begin
            state_q     <= EV_BUSY;
            evict_bytes <= size_i;
            evict_count <= cnt_next;
         end else if (evict_done) begin
            state_q <= EV_IDLE;
         end
      end
   end
endmodule

// File: rtl/evict_trigger.sv
module evict_trigger #(
   parameter int BYTE_W          = 32,
   parameter int PAGE_BYTES      = 65536,
   parameter int MAX_EVICT_BYTES = 2097152,
   parameter int THRESH_BYTES    = 2097152,
   parameter int CNT_W           = 16,
   parameter bit CNT_SAT         = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_evt,
   input  logic              alloc_done,
   input  logic [BYTE_W-1:0] alloc_bytes,
   input  logic [BYTE_W-1:0] free_bytes,
   input  logic              oversub,
   input  logic              regular_en,
   input  logic              evict_done,
   output logic              evict_req,
   output logic [BYTE_W-1:0] evict_bytes,
   output logic [CNT_W-1:0]  evict_count
);
   localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);
   localparam int MAX_PAGES  = MAX_EVICT_BYTES / PAGE_BYTES;
   localparam int PG_W       = BYTE_W - PAGE_SHIFT;

   generate
      if ((1 << PAGE_SHIFT) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two");
      end
      if (MAX_PAGES < 1 || (MAX_PAGES * PAGE_BYTES) != MAX_EVICT_BYTES) begin : g_bad_max
         $error("MAX_EVICT_BYTES must be a whole number of pages, at least one");
      end
      if (PG_W < 1 || BYTE_W > 32) begin : g_bad_width
         $error("BYTE_W must exceed the page shift and be at most 32");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic              fault_seen;
   logic              cond;
   logic [BYTE_W-1:0] size_w;

   evt_fault_latch u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_evt  (fault_evt),
      .alloc_done (alloc_done),
      .fault_seen (fault_seen)
   );

   evt_qualify #(.BYTE_W(BYTE_W), .THRESH_BYTES(THRESH_BYTES)) u_qual (
      .fault_seen  (fault_seen),
      .alloc_done  (alloc_done),
      .alloc_bytes (alloc_bytes),
      .free_bytes  (free_bytes),
      .oversub     (oversub),
      .regular_en  (regular_en),
      .cond        (cond)
   );

   evt_sizer #(.BYTE_W(BYTE_W), .PAGE_SHIFT(PAGE_SHIFT), .MAX_PAGES(MAX_PAGES)) u_size (
      .pages_i (alloc_bytes[BYTE_W-1:PAGE_SHIFT]),
      .size_o  (size_w)
   );

   evt_issuer #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_issue (
      .clk         (clk),
      .rst_n       (rst_n),
      .cond        (cond),
      .size_i      (size_w),
      .evict_done  (evict_done),
      .evict_req   (evict_req),
      .evict_bytes (evict_bytes),
      .evict_count (evict_count)
   );
endmodule

// File: rtl/evict_trigger_chk.sv
module evict_trigger_chk #(
   parameter int BYTE_W          = 32,
   parameter int PAGE_BYTES      = 65536,
   parameter int MAX_EVICT_BYTES = 2097152,
   parameter int THRESH_BYTES    = 2097152,
   parameter int CNT_W           = 16,
   parameter bit CNT_SAT         = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              alloc_done,
   input logic [BYTE_W-1:0] free_bytes,
   input logic              oversub,
   input logic              regular_en,
   input logic              evict_done,
   input logic              evict_req,
   input logic [BYTE_W-1:0] evict_bytes,
   input logic [CNT_W-1:0]  evict_count
);
   localparam logic [BYTE_W-1:0] THRESH_V = BYTE_W'(THRESH_BYTES);
   localparam logic [BYTE_W-1:0] PAGE_V   = BYTE_W'(PAGE_BYTES);
   localparam logic [BYTE_W-1:0] MAX_V    = BYTE_W'(MAX_EVICT_BYTES);

   // R4
   req_after_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict_req |-> $past(alloc_done));

   // R6
   irregular_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !regular_en |=> !evict_req);

   // R3
   not_oversub_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oversub |=> !evict_req);

   // R3
   above_thresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_bytes >= THRESH_V) |=> !evict_req);

   // R7
   one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_req && !evict_done) |=> !evict_req);

   // R8
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict_req |-> (evict_count == ((CNT_SAT && (&$past(evict_count))) ?
                     $past(evict_count) : CNT_W'($past(evict_count) + 1'b1))));

   // R8
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !evict_req |-> $stable(evict_count));

   // R5
   always @(posedge clk) begin
      if (rst_n && evict_req) begin
         size_range_chk: assert (evict_bytes >= PAGE_V && evict_bytes <= MAX_V &&
                                 (evict_bytes % PAGE_V) == '0);
      end
   end
endmodule

bind evict_trigger evict_trigger_chk #(
   .BYTE_W(BYTE_W), .PAGE_BYTES(PAGE_BYTES), .MAX_EVICT_BYTES(MAX_EVICT_BYTES),
   .THRESH_BYTES(THRESH_BYTES), .CNT_W(CNT_W), .CNT_SAT(CNT_SAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_done(alloc_done), .free_bytes(free_bytes),
   .oversub(oversub), .regular_en(regular_en), .evict_done(evict_done),
   .evict_req(evict_req), .evict_bytes(evict_bytes), .evict_count(evict_count)
);

// File: tb/sim_evict_trigger.sv
module sim_evict_trigger;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fault_evt = 1'b0, alloc_done = 1'b0;
   logic [31:0] alloc_bytes = '0, free_bytes = '0;
   logic        oversub = 1'b1, regular_en = 1'b1, evict_done = 1'b0;
   logic        evict_req;
   logic [31:0] evict_bytes;
   logic [15:0] evict_count;

   int    errors = 0, checks = 0;
   bit    finished = 0;
   string tag = "R1";

   // behavioural reference state
   bit      m_req = 0, m_busy = 0, m_pend = 0;
   longint  m_bytes = 0;
   int      m_count = 0;

   always #5 clk = ~clk;

   evict_trigger u0 (
      .clk(clk), .rst_n(rst_n), .fault_evt(fault_evt), .alloc_done(alloc_done),
      .alloc_bytes(alloc_bytes), .free_bytes(free_bytes), .oversub(oversub),
      .regular_en(regular_en), .evict_done(evict_done), .evict_req(evict_req),
      .evict_bytes(evict_bytes), .evict_count(evict_count)
   );

   function automatic longint ref_size(longint a);
      longint p;
      p = (a / 65536) * 65536;
      if (p < 65536) p = 65536;
      if (p > 2097152) p = 2097152;
      return p;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_req = 0; m_busy = 0; m_pend = 0; m_bytes = 0; m_count = 0;
      end else begin
         bit go;
         go = alloc_done && (m_pend || fault_evt) && regular_en && oversub &&
              (longint'(alloc_bytes) > longint'(free_bytes)) &&
              (longint'(free_bytes) < 2097152) && (!m_busy || evict_done);
         m_req = go;
         if (go) begin
            m_bytes = ref_size(longint'(alloc_bytes));
            m_count = (m_count + 1) % 65536;
            m_busy  = 1;
         end else if (evict_done) begin
            m_busy = 0;
         end
         if (alloc_done) m_pend = 0;
         else if (fault_evt) m_pend = 1;
      end
   end

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (!finished) begin
         chk(evict_req == m_req, {tag, " req"}, evict_req, m_req);
         chk(int'(evict_count) == m_count, "R8 count", evict_count, m_count);
         if (m_req) chk(longint'(evict_bytes) == m_bytes, "R5 bytes", evict_bytes, m_bytes);
      end
   end

   task automatic cyc();
      @(negedge clk); #2;
   endtask

   task automatic fault();
      fault_evt = 1; cyc(); fault_evt = 0;
   endtask

   task automatic alloc(longint a, longint f, bit with_fault, bit with_done);
      alloc_bytes = 32'(a); free_bytes = 32'(f);
      alloc_done = 1; fault_evt = with_fault; evict_done = with_done;
      cyc();
      alloc_done = 0; fault_evt = 0; evict_done = 0;
   endtask

   task automatic release_ev();
      evict_done = 1; cyc(); evict_done = 0;
   endtask

   // sampled at negedge+2 of the cycle after the alloc cycle
   task automatic expect_req(bit er, longint eb, string req);
      chk(evict_req == er, req, evict_req, er);
      if (er) chk(longint'(evict_bytes) == eb, req, evict_bytes, eb);
   endtask

   initial begin
      #1;
      chk(evict_req == 0, "R1 req in reset", evict_req, 0);
      chk(evict_count == 0, "R1 count in reset", evict_count, 0);
      repeat (3) cyc();
      rst_n = 1;
      cyc();
      chk(evict_req == 0 && evict_count == 0, "R1 after reset", evict_req, 0);

      tag = "R2";
      alloc(300000, 100000, 0, 0);          expect_req(0, 0, "R2 alloc without fault");
      fault(); cyc();                        expect_req(0, 0, "R2 fault without alloc");
      tag = "R9";
      cyc(); cyc();
      alloc(300000, 100000, 0, 0);          expect_req(1, 262144, "R9 pending across idle");
      cyc();                                 expect_req(0, 0, "R4 one cycle wide");
      release_ev();
      alloc(300000, 100000, 0, 0);          expect_req(0, 0, "R9 pending used once");

      tag = "R5";
      fault(); alloc(30000, 1000, 0, 0);    expect_req(1, 65536, "R5 below one page");
      release_ev();
      fault(); alloc(5000000, 1000000, 0, 0); expect_req(1, 2097152, "R5 capped");
      release_ev();

      tag = "R3";
      fault(); alloc(3000000, 2097152, 0, 0); expect_req(0, 0, "R3 free at threshold");
      fault(); alloc(500000, 500000, 0, 0);   expect_req(0, 0, "R3 alloc equals free");
      oversub = 0;
      fault(); alloc(300000, 100000, 0, 0);   expect_req(0, 0, "R3 not oversubscribed");
      oversub = 1;

      tag = "R6";
      regular_en = 0;
      fault(); alloc(300000, 100000, 0, 0);   expect_req(0, 0, "R6 irregular class");
      regular_en = 1;
      alloc(300000, 100000, 0, 0);            expect_req(0, 0, "R6 fault consumed");

      tag = "R7";
      fault(); alloc(300000, 100000, 0, 0);   expect_req(1, 262144, "R7 first request");
      fault(); alloc(700000, 100000, 0, 0);   expect_req(0, 0, "R7 blocked while busy");
      fault(); alloc(700000, 100000, 0, 1);   expect_req(1, 655360, "R7 done in same cycle");
      release_ev();

      tag = "R9";
      alloc(140000, 0, 1, 0);                 expect_req(1, 131072, "R9 fault with alloc");
      release_ev();
      cyc();
      chk(evict_count == 6, "R8 total requests", evict_count, 6);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2000000;
      if (!finished) begin
         finished = 1;
         errors++; checks++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule